// File: doc/BRIEF.md
# Manchester Fieldbus Frame Serializer

This block sends one fieldbus frame on a serial line, clocked from the system clock. A start pulse opens the frame. The block first emits a fixed header: an alternating training pattern followed by a start delimiter that contains code-violation symbols. It then asks for payload bytes one at a time. Each byte it receives is Manchester-encoded onto the line and folded into a running 16-bit check value. The frame closes with the complemented check value and an end delimiter that also carries violation symbols.

The byte source answers each request with an accept pulse carrying the byte. It marks the final byte with a flag. If it stays silent for one bit period, the frame is closed with the bytes already sent. A rate code, sampled at the start pulse, selects one of four bit periods. A free-running watchdog aborts any frame that outlasts its limit.

Top module: `mfb_tx`

## Requirements
- R1: The rate code is sampled with the start pulse and selects the bit period. Codes 0, 1, 2 and 3 select `BIT_T0`, `BIT_T1`, `BIT_T2` and `BIT_T3` system clocks, with defaults 3200, 100, 40 and 20. Changes of the rate code during a frame have no effect on that frame.
- R2: Each symbol is two half-bits, and each half-bit lasts half the bit period. The half-bits are: data 1 = high, low; data 0 = low, high; violation V+ = high, high; violation V- = low, low.
- R3: The first half-bit starts on the clock edge after the one that samples start. The header is the symbols 1,0,1,0,1,0,1,0 followed by 1,V+,V-,1,0,V-,V+,0.
- R4: `byte_req` is a one-cycle pulse issued while `tx_en` is high. It rises on the edge that starts the third-to-last half-bit of the header, or of a data byte that was not flagged last. Data bits are sent MSB first.
- R5: An accept pulse counts if it is sampled on any of the 2 x half-bit-period edges that follow a request. Such an accept loads `byte_in`, and `byte_last` taken with it marks the final byte. With no accept in that window, the check field and end delimiter follow the bytes already sent. Accepts outside a window are ignored.
- R6: The check value uses the generator x^16 + 0x1DCF. It is preset to 0xFFFF at start, updated MSB first over every data bit, and sent as its one's complement, MSB first, in 16 data symbols.
- R7: The frame ends with the symbols 1,V+,V-,V+,V-,1,0,1. `tx_en` is high from the first header half-bit through the last end-delimiter half-bit. `txd` is low whenever `tx_en` is low.
- R8: `done` pulses for one cycle on the edge where the last half-bit ends, the same edge on which `tx_en` falls.
- R9: `WD_LIMIT` clock edges after the first half-bit (default 2^25-1), an unfinished frame is aborted. `tx_en` and `txd` drop, and no `done` pulse is given.
- R10: A start pulse while a frame is in progress is ignored.
- R11: After reset `txd`, `tx_en`, `byte_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate | input | 2 | Bit-rate code, sampled at start |
| start | input | 1 | Start-of-frame pulse |
| byte_in | input | 8 | Payload byte offered with an accept |
| byte_acc | input | 1 | Accept pulse answering a request |
| byte_last | input | 1 | Marks the accepted byte as the final one |
| byte_req | output | 1 | Request pulse for the next payload byte |
| txd | output | 1 | Serial line data |
| tx_en | output | 1 | Line-driver enable, high for the whole frame |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
Frames are sent at all four rate codes with differing byte counts and payloads. The bench samples every half-bit in its middle and compares it with a stream it builds itself, which separates errors in symbol encoding, bit order and check-value arithmetic. The accept delay is swept across the window: immediate, one cycle inside the window's end, and one cycle past it. The past-window case must yield an empty frame with the late accept ignored. Frames cut short by a silent source, a start pulse issued mid-frame, a rate change mid-frame, and a frame longer than the watchdog limit each probe one of the control paths.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

  // Header as half-bit levels, MSB first: training pattern then start delimiter
  localparam logic [31:0] HDR_HALVES = 32'h9999_B24D;
  // End delimiter as half-bit levels, MSB first
  localparam logic [15:0] END_HALVES = 16'hB326;
  localparam logic [15:0] CHK_POLY   = 16'h1DCF;
  localparam logic [15:0] CHK_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    SEG_IDLE, SEG_HDR, SEG_DATA, SEG_CHK, SEG_END, SEG_TAIL
  } seg_t;

  function automatic logic [15:0] manch8(input logic [7:0] b);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[2*i+1] = b[i];
      r[2*i]   = ~b[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] manch16(input logic [15:0] w);
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      r[2*i+1] = w[i];
      r[2*i]   = ~w[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] chk_step(input logic [15:0] c, input logic d);
    logic fb;
    fb = c[15] ^ d;
    return {c[14:0], 1'b0} ^ (fb ? CHK_POLY : 16'h0000);
  endfunction

  function automatic logic [15:0] chk_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) r = chk_step(r, b[i]);
    return r;
  endfunction

endpackage

// File: rtl/mfb_half_timer.sv
module mfb_half_timer #(
  parameter int BIT_T0 = 3200,
  parameter int BIT_T1 = 100,
  parameter int BIT_T2 = 40,
  parameter int BIT_T3 = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int M01  = (BIT_T0 > BIT_T1) ? BIT_T0 : BIT_T1;
  localparam int M23  = (BIT_T2 > BIT_T3) ? BIT_T2 : BIT_T3;
  localparam int TMAX = (M01 > M23) ? M01 : M23;
  localparam int CW   = $clog2(TMAX / 2 + 1);

  logic [CW-1:0] cnt_q, half_q;

  function automatic logic [CW-1:0] half_for(input logic [1:0] r);
    case (r)
      2'd0:    return CW'(BIT_T0 / 2 - 1);
      2'd1:    return CW'(BIT_T1 / 2 - 1);
      2'd2:    return CW'(BIT_T2 / 2 - 1);
      default: return CW'(BIT_T3 / 2 - 1);
    endcase
  endfunction

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
    end else if (restart) begin
      cnt_q  <= '0;
      half_q <= half_for(rate);
    end else if (tick) begin
      cnt_q <= half_q;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R1
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_q);

endmodule

// File: rtl/mfb_chk16.sv
module mfb_chk16 import mfb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [15:0] chk
);
  always_ff @(posedge clk) begin
    if (!rst_n)    chk <= CHK_PRESET;
    else if (init) chk <= CHK_PRESET;
    else if (upd)  chk <= chk_byte(chk, data);
  end
endmodule

// File: rtl/mfb_watchdog.sv
module mfb_watchdog #(
  parameter int LIMIT = 2**25 - 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign expire = run && (cnt_q == W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (run && !expire)   cnt_q <= cnt_q + 1'b1;
  end

  // R9
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(LIMIT));

endmodule

// File: rtl/mfb_tx.sv
module mfb_tx import mfb_pkg::*; #(
  parameter int BIT_T0   = 3200,
  parameter int BIT_T1   = 100,
  parameter int BIT_T2   = 40,
  parameter int BIT_T3   = 20,
  parameter int WD_LIMIT = 2**25 - 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate,
  input  logic       start,
  input  logic [7:0] byte_in,
  input  logic       byte_acc,
  input  logic       byte_last,
  output logic       byte_req,
  output logic       txd,
  output logic       tx_en,
  output logic       done
);
  localparam int LW = 6;

  logic          busy_q, txd_q, en_q, done_q, req_q;
  logic          wait_q, got_q, last_q, fin_q;
  logic [7:0]    byte_q;
  seg_t          seg_q;
  logic [31:0]   sh_q;
  logic [LW-1:0] left_q;
  logic [15:0]   chk;

  // Named internal events
  logic       tick, wd_expire;
  logic       start_ok, acc_now, seg_end, want_byte, take;
  logic [7:0] take_byte;
  logic       take_last;

  assign start_ok  = start && !busy_q;
  assign acc_now   = wait_q && byte_acc;
  assign seg_end   = tick && (seg_q != SEG_TAIL) && (left_q == LW'(1));
  assign want_byte = (seg_q == SEG_HDR) || ((seg_q == SEG_DATA) && !fin_q);
  assign take      = seg_end && want_byte && (got_q || acc_now);
  assign take_byte = got_q ? byte_q : byte_in;
  assign take_last = got_q ? last_q : byte_last;

  mfb_half_timer #(
    .BIT_T0(BIT_T0), .BIT_T1(BIT_T1), .BIT_T2(BIT_T2), .BIT_T3(BIT_T3)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(start_ok), .run(busy_q),
    .rate(rate), .tick(tick)
  );

  mfb_chk16 u_chk (
    .clk(clk), .rst_n(rst_n), .init(start_ok), .upd(take),
    .data(take_byte), .chk(chk)
  );

  mfb_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .run(busy_q),
    .expire(wd_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; txd_q <= 1'b0; en_q <= 1'b0; done_q <= 1'b0;
      req_q  <= 1'b0; wait_q <= 1'b0; got_q <= 1'b0; last_q <= 1'b0;
      fin_q  <= 1'b0; byte_q <= '0; seg_q <= SEG_IDLE; sh_q <= '0;
      left_q <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      if (acc_now && !got_q) begin
        got_q  <= 1'b1;
        byte_q <= byte_in;
        last_q <= byte_last;
      end
      if (wd_expire) begin
        busy_q <= 1'b0; en_q <= 1'b0; txd_q <= 1'b0;
        wait_q <= 1'b0; got_q <= 1'b0; seg_q <= SEG_IDLE;
      end else if (start_ok) begin
        busy_q <= 1'b1;
        seg_q  <= SEG_HDR;
        sh_q   <= HDR_HALVES;
        left_q <= LW'(32);
        fin_q  <= 1'b0;
        wait_q <= 1'b0;
        got_q  <= 1'b0;
      end else if (tick) begin
        if (seg_q == SEG_TAIL) begin
          busy_q <= 1'b0; en_q <= 1'b0; txd_q <= 1'b0;
          done_q <= 1'b1; seg_q <= SEG_IDLE;
        end else begin
          txd_q  <= sh_q[31];
          en_q   <= 1'b1;
          sh_q   <= {sh_q[30:0], 1'b0};
          left_q <= left_q - 1'b1;
          if (left_q == LW'(3) && want_byte) begin
            req_q  <= 1'b1;
            wait_q <= 1'b1;
          end
          if (left_q == LW'(1)) begin
            wait_q <= 1'b0;
            got_q  <= 1'b0;
            case (seg_q)
              SEG_HDR, SEG_DATA: begin
                if (take) begin
                  seg_q  <= SEG_DATA;
                  sh_q   <= {manch8(take_byte), 16'h0000};
                  left_q <= LW'(16);
                  fin_q  <= take_last;
                end else begin
                  seg_q  <= SEG_CHK;
                  sh_q   <= manch16(~chk);
                  left_q <= LW'(32);
                end
              end
              SEG_CHK: begin
                seg_q  <= SEG_END;
                sh_q   <= {END_HALVES, 16'h0000};
                left_q <= LW'(16);
              end
              default: seg_q <= SEG_TAIL;
            endcase
          end
        end
      end
    end
  end

  assign byte_req = req_q;
  assign txd      = txd_q;
  assign tx_en    = en_q;
  assign done     = done_q;

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !txd);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tx_en && $past(tx_en)));
  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);
  // R4
  req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> tx_en);

endmodule

// File: tb/test_mfb_tx.sv
module test_mfb_tx;
  localparam int CLK_P = 10;
  localparam int T0 = 320, T1 = 100, T2 = 40, T3 = 20;
  localparam int WDL = 20000;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic       byte_acc = 1'b0, byte_last = 1'b0;
  logic [1:0] rate = 2'd0;
  logic [7:0] byte_in = 8'h00;
  wire        byte_req, txd, tx_en, done;

  int n_chk = 0, n_fail = 0;
  bit exp_h [0:1023];
  int n_h;

  mfb_tx #(.BIT_T0(T0), .BIT_T1(T1), .BIT_T2(T2), .BIT_T3(T3), .WD_LIMIT(WDL)) i_mfb_tx (
    .clk(clk), .rst_n(rst_n), .rate(rate), .start(start), .byte_in(byte_in),
    .byte_acc(byte_acc), .byte_last(byte_last), .byte_req(byte_req),
    .txd(txd), .tx_en(tx_en), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input int r);
    case (r)
      0: return T0 / 2;
      1: return T1 / 2;
      2: return T2 / 2;
      default: return T3 / 2;
    endcase
  endfunction

  // symbol codes: 0 = data 0, 1 = data 1, 2 = V+, 3 = V-
  task automatic put_sym(input int s);
    case (s)
      0: begin exp_h[n_h] = 0; exp_h[n_h+1] = 1; end
      1: begin exp_h[n_h] = 1; exp_h[n_h+1] = 0; end
      2: begin exp_h[n_h] = 1; exp_h[n_h+1] = 1; end
      default: begin exp_h[n_h] = 0; exp_h[n_h+1] = 0; end
    endcase
    n_h += 2;
  endtask

  task automatic run_frame(input int rsel, input int nb, input int give, input int dly,
                           input int restart_k, input string tag);
    int h, ne, end_k, nreq, answered, sched, exp_req, c;
    int hdr[16] = '{1,0,1,0,1,0,1,0, 1,2,3,1,0,3,2,0};
    int trl[8]  = '{1,2,3,2,3,1,0,1};
    logic [7:0] dat [0:7];
    h = half_of(rsel);
    for (int i = 0; i < 8; i++) dat[i] = 8'((i * 61 + 17) ^ (rsel * 85));
    ne = (dly < 2 * h) ? ((give < nb) ? give : nb) : 0;
    exp_req = (ne < nb) ? ne + 1 : nb;
    n_h = 0;
    for (int i = 0; i < 16; i++) put_sym(hdr[i]);
    c = 16'hFFFF;
    for (int i = 0; i < ne; i++)
      for (int b = 7; b >= 0; b--) begin
        int d, fb;
        d  = dat[i][b];
        put_sym(d);
        fb = ((c >> 15) & 1) ^ d;
        c  = (c << 1) & 16'hFFFF;
        if (fb != 0) c = c ^ 16'h1DCF;
      end
    c = (~c) & 16'hFFFF;
    for (int b = 15; b >= 0; b--) put_sym((c >> b) & 1);
    for (int i = 0; i < 8; i++) put_sym(trl[i]);
    end_k = n_h * h;
    nreq = 0; answered = 0; sched = -1;

    @(negedge clk);
    rate = 2'(rsel); start = 1'b1;
    @(negedge clk);
    start = 1'b0; rate = 2'(rsel + 1);   // R1: later rate change must not matter
    for (int k = 0; k <= end_k + 2; k++) begin
      @(negedge clk);
      byte_acc = 1'b0; byte_last = 1'b0;
      start = (k == restart_k);           // R10: start mid-frame
      if (byte_req) begin
        nreq++;
        if (nreq == 1) chk(k == 29 * h, {"R4 first request slot ", tag}, k, 29 * h);
        if (answered < give) sched = k + dly;
      end
      if (k == sched) begin
        byte_acc = 1'b1; byte_in = dat[answered];
        byte_last = (answered == nb - 1);
        answered++; sched = -1;
      end
      if (k < end_k && (k % h) == h / 2)
        chk(txd == exp_h[k / h] && tx_en,
            {"R2 R3 R6 R7 half-bit ", tag}, int'({tx_en, txd}), int'({1'b1, exp_h[k / h]}));
      if (k == end_k - 1) chk(!done && tx_en, {"R8 before end ", tag}, int'({done, tx_en}), 1);
      if (k == end_k)     chk(done && !tx_en, {"R8 done pulse ", tag}, int'({done, tx_en}), 2);
      if (k == end_k + 1) chk(!done, {"R8 done single ", tag}, int'(done), 0);
    end
    start = 1'b0;
    chk(nreq == exp_req, {"R5 request count ", tag}, nreq, exp_req);
    repeat (3) @(negedge clk);
  endtask

  task automatic wd_test();
    bit saw_done;
    int answered;
    saw_done = 0; answered = 0;
    @(negedge clk);
    rate = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= WDL + 100; k++) begin
      @(negedge clk);
      byte_acc = 1'b0; byte_last = 1'b0;
      if (byte_req && answered < 4) begin
        byte_acc = 1'b1; byte_in = 8'(answered + 8'hA0);
        byte_last = (answered == 3); answered++;
      end
      if (done) saw_done = 1;
      if (k == WDL - 10) chk(tx_en, "R9 still sending before limit", int'(tx_en), 1);
      if (k == WDL + 10) chk(!tx_en && !txd, "R9 aborted after limit", int'({tx_en, txd}), 0);
    end
    chk(!saw_done, "R9 no done on abort", int'(saw_done), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!txd && !tx_en && !byte_req && !done, "R11 reset outputs",
        int'({txd, tx_en, byte_req, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!txd && !tx_en && !byte_req && !done, "R11 idle after reset",
        int'({txd, tx_en, byte_req, done}), 0);
    run_frame(3, 3, 3, 0,  -1,  "R1 rate3 three bytes");
    run_frame(1, 2, 2, 99, 150, "R5 R10 window edge with restart");
    run_frame(2, 3, 1, 0,  -1,  "R5 source stops after one");
    run_frame(2, 2, 1, 40, -1,  "R5 late accept ignored");
    run_frame(0, 1, 1, 5,  -1,  "R1 rate0 one byte");
    run_frame(3, 2, 2, 7,  -1,  "R4 rate3 delayed");
    wd_test();
    run_frame(3, 1, 1, 0,  -1,  "R9 recovery after abort");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule